// File: doc/BRIEF.md
# ATA Task-File Address Mode Decoder

This block sits between the host side of a removable storage card and an ATA drive port. It takes 16-bit host reads and writes in common-memory or I/O space and turns them into task-file register accesses. How it does this depends on a two-bit addressing mode supplied by the card's configuration logic. In memory-mapped mode, a 1 KiB window is folded onto the data register. In contiguous I/O mode, the low address nibble selects the register directly. In the primary and secondary legacy modes, a command block and a control block are each folded onto one 16-entry register map.

Three registers never reach the drive. The device-control register is held locally, and a write that sets its soft-reset bit produces a card reset. The alternate-status read is answered from the drive's status byte, or with zero when no drive is present. The device-address read is built by the card from the drive-select bits.

The configuration block can flag the card as powered down. While that flag is set, a write to an ordinary task-file register sends single-cycle pulses back to that block. One pulse clears the power-down state and the other raises card-ready.

Top module: `ata_window_decoder`

## Requirements
- R1: In mode 0 (memory-mapped), any host address from 0x400 to 0x7FF folds to register offset 0. Any other address uses its low 4 bits as the offset.
- R2: In mode 1 (contiguous I/O), the offset is the low 4 bits of the host address.
- R3: In mode 2 (primary), addresses 0x3F0–0x3FF fold to offset (address − 0x3E8) modulo 16. Every other address, including 0x1F0–0x1FF, uses its low 4 bits.
- R4: In mode 3 (secondary), addresses 0x370–0x37F fold to offset (address − 0x368) modulo 16. Every other address, including 0x170–0x17F, uses its low 4 bits.
- R5: An address outside a mode's window keeps its low 4 bits as the offset. No access is dropped.
- R6: Offsets 0x0 and 0x8 reach the drive as task-file index 0, the 16-bit data port. Offset 0xD reaches it as index 1. Offsets 0x1–0x7, 0x9–0xC, and 0xF on writes, pass through with their own value as the index.
- R7: A read at offset 0xE does not touch the drive. It returns the drive status byte when `drive_present` is 1, and 0 otherwise.
- R8: A read at offset 0xF does not touch the drive. It returns 0xC2 | ((~sel << 2) & 0x3C), where sel is the 4-bit drive-select value.
- R9: A write at offset 0xE does not touch the drive and loads `devctl` with the low data byte. If data bit 2 (soft reset) is set, `devctl` becomes 0 instead and `card_reset` pulses for one cycle.
- R10: A pass-through write at any offset other than 0x0, 0x8, 0xD or 0xE, made while `pwrdn_state` is 1, pulses `pwrdn_clr` and `crdy_set` for one cycle, together with the drive write. Writes at offsets 0x0, 0x8 and 0xD never pulse them.
- R11: A drive strobe is a one-cycle pulse in the cycle after the host strobe. Read data appears with `host_rvalid` exactly two cycles after the host read strobe.
- R12: If `host_rd` and `host_wr` are high together, only the write is performed. No drive read is issued and no read data is returned.
- R13: After reset, all strobes and pulses are 0, and `devctl` and `host_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Addressing mode: 0 memory, 1 contiguous I/O, 2 primary, 3 secondary |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rdata | output | DATA_W | Read data, valid when host_rvalid is 1 |
| host_rvalid | output | 1 | Read data valid pulse |
| tf_rd | output | 1 | Task-file read strobe to the drive |
| tf_wr | output | 1 | Task-file write strobe to the drive |
| tf_index | output | 4 | Task-file register index |
| tf_wdata | output | DATA_W | Data toward the drive |
| drive_rdata | input | DATA_W | Drive read data, valid while tf_rd is 1 |
| drive_present | input | 1 | A drive is attached |
| drive_status | input | 8 | Drive status byte |
| drive_sel | input | 4 | Low nibble of the drive-select register |
| pwrdn_state | input | 1 | Card is currently powered down |
| pwrdn_clr | output | 1 | Pulse: clear the power-down state |
| crdy_set | output | 1 | Pulse: raise card-ready |
| devctl | output | 8 | Device-control register |
| card_reset | output | 1 | Pulse: soft reset requested through device control |

## Verification
Directed accesses are made at the edges of each mode's windows: 0x400 and 0x7FF in memory mode, and the control blocks 0x3F0/0x3FF and 0x370/0x37F. Matching addresses outside those windows show whether folding happens only inside a window. The same offset is reached through different modes, for reads and for writes. This shows whether the data, error/feature, alternate-status and device-address cases are told apart by offset and not by address. Random accesses draw the mode, the address (biased toward the windows), the direction, the power-down flag, the drive presence and the select bits. Each result is compared with a reference fold computed in the bench.

// File: rtl/atawin_pkg.sv
package atawin_pkg;

  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    AM_MEM  = 2'd0,
    AM_IO16 = 2'd1,
    AM_PRI  = 2'd2,
    AM_SEC  = 2'd3
  } amode_t;

  // Legacy control-block windows; their offset is the low nibble plus 8.
  localparam int PRI_CTL_BASE = 'h3F0;
  localparam int SEC_CTL_BASE = 'h370;
  localparam logic [IDX_W-1:0] CTL_BIAS = 4'd8;

  // Local register offsets inside the folded map.
  localparam logic [IDX_W-1:0] OFF_DATA_LO = 4'h0;
  localparam logic [IDX_W-1:0] OFF_DATA_HI = 4'h8;
  localparam logic [IDX_W-1:0] OFF_ERRFEAT = 4'hD;
  localparam logic [IDX_W-1:0] OFF_CTLSTAT = 4'hE;
  localparam logic [IDX_W-1:0] OFF_DEVADDR = 4'hF;

  localparam logic [IDX_W-1:0] IDX_DATA    = 4'h0;
  localparam logic [IDX_W-1:0] IDX_ERRFEAT = 4'h1;

  localparam int SRST_BIT = 2;

  // Card-built device address byte from the select nibble.
  function automatic logic [7:0] devaddr_byte(input logic [3:0] sel);
    return {2'b11, ~sel, 2'b10};
  endfunction

endpackage

// File: rtl/atawin_fold.sv
module atawin_fold
  import atawin_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int MEM_SHIFT = 10,
  parameter int MEM_BASE  = 'h400
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  off
);

  localparam int NWIN = 2;

  logic            mem_hit;
  logic [NWIN-1:0] ctl_hit;
  logic [IDX_W-1:0] low;

  assign low     = addr[IDX_W-1:0];
  assign mem_hit = (int'(addr >> MEM_SHIFT) == (MEM_BASE >> MEM_SHIFT));

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int CTL_B = (w == 0) ? PRI_CTL_BASE : SEC_CTL_BASE;
    assign ctl_hit[w] = (int'(addr[ADDR_W-1:IDX_W]) == (CTL_B >> IDX_W));
  end

  always_comb begin
    unique case (amode_t'(mode))
      AM_MEM:  off = mem_hit ? OFF_DATA_LO : low;
      AM_IO16: off = low;
      AM_PRI:  off = ctl_hit[0] ? low + CTL_BIAS : low;
      AM_SEC:  off = ctl_hit[1] ? low + CTL_BIAS : low;
      default: off = low;
    endcase
  end

endmodule

// File: rtl/atawin_classify.sv
module atawin_classify
  import atawin_pkg::*;
(
  input  logic [IDX_W-1:0] off,
  output logic             is_data,
  output logic             is_errfeat,
  output logic             is_ctlstat,
  output logic             is_devaddr,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    is_data    = (off == OFF_DATA_LO) || (off == OFF_DATA_HI);
    is_errfeat = (off == OFF_ERRFEAT);
    is_ctlstat = (off == OFF_CTLSTAT);
    is_devaddr = (off == OFF_DEVADDR);
    if (is_data)         idx = IDX_DATA;
    else if (is_errfeat) idx = IDX_ERRFEAT;
    else                 idx = off;
  end

endmodule

// File: rtl/atawin_devctl.sv
module atawin_devctl
  import atawin_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] devctl,
  output logic             card_reset
);

  always_ff @(posedge clk) begin
    if (rst) begin
      devctl     <= '0;
      card_reset <= 1'b0;
    end else begin
      card_reset <= 1'b0;
      if (wr_en) begin
        if (wdata[SRST_BIT]) begin
          devctl     <= '0;
          card_reset <= 1'b1;
        end else begin
          devctl <= wdata;
        end
      end
    end
  end

  // R9
  srst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    card_reset |-> (devctl == '0 && $past(wr_en)));

endmodule

// File: rtl/ata_window_decoder.sv
module ata_window_decoder
  import atawin_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int REG_W     = 8,
  parameter int MEM_SHIFT = 10,
  parameter int MEM_BASE  = 'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic [3:0]        tf_index,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] drive_rdata,
  input  logic              drive_present,
  input  logic [REG_W-1:0]  drive_status,
  input  logic [3:0]        drive_sel,
  input  logic              pwrdn_state,
  output logic              pwrdn_clr,
  output logic              crdy_set,
  output logic [REG_W-1:0]  devctl,
  output logic              card_reset
);

  localparam int PAD_W = DATA_W - REG_W;

  logic [IDX_W-1:0] off, idx;
  logic is_data, is_errfeat, is_ctlstat, is_devaddr;
  logic acc_rd, acc_wr, wake;
  logic [REG_W-1:0] loc_byte;

  // Stage-1 read bookkeeping
  logic             rd_s1, loc_s1;
  logic [REG_W-1:0] loc_val_s1;

  atawin_fold #(
    .ADDR_W(ADDR_W), .MEM_SHIFT(MEM_SHIFT), .MEM_BASE(MEM_BASE)
  ) i_fold (
    .mode(mode), .addr(host_addr), .off(off)
  );

  atawin_classify i_class (
    .off(off), .is_data(is_data), .is_errfeat(is_errfeat),
    .is_ctlstat(is_ctlstat), .is_devaddr(is_devaddr), .idx(idx)
  );

  atawin_devctl #(.REG_W(REG_W)) i_devctl (
    .clk(clk), .rst(rst),
    .wr_en(acc_wr && is_ctlstat),
    .wdata(host_wdata[REG_W-1:0]),
    .devctl(devctl), .card_reset(card_reset)
  );

  // Writes win over a simultaneous read.
  assign acc_wr = host_wr;
  assign acc_rd = host_rd && !host_wr;
  assign wake   = acc_wr && pwrdn_state &&
                  !(is_data || is_errfeat || is_ctlstat);

  always_comb begin
    if (is_ctlstat) loc_byte = drive_present ? drive_status : '0;
    else            loc_byte = devaddr_byte(drive_sel);
  end

  // Stage 1: drive-side strobes and local read capture
  always_ff @(posedge clk) begin
    if (rst) begin
      tf_rd      <= 1'b0;
      tf_wr      <= 1'b0;
      tf_index   <= '0;
      tf_wdata   <= '0;
      pwrdn_clr  <= 1'b0;
      crdy_set   <= 1'b0;
      rd_s1      <= 1'b0;
      loc_s1     <= 1'b0;
      loc_val_s1 <= '0;
    end else begin
      tf_wr     <= acc_wr && !is_ctlstat;
      tf_rd     <= acc_rd && !(is_ctlstat || is_devaddr);
      pwrdn_clr <= wake;
      crdy_set  <= wake;
      rd_s1     <= acc_rd;
      loc_s1    <= acc_rd && (is_ctlstat || is_devaddr);
      if (acc_rd || acc_wr) tf_index <= idx;
      if (acc_wr)           tf_wdata <= host_wdata;
      if (acc_rd)           loc_val_s1 <= loc_byte;
    end
  end

  // Stage 2: read return
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_s1;
      if (rd_s1)
        host_rdata <= loc_s1 ? {{PAD_W{1'b0}}, loc_val_s1} : drive_rdata;
    end
  end

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tf_rd, tf_wr}));

  // R11
  wr_follows_host_chk: assert property (@(posedge clk) disable iff (rst)
    tf_wr |-> $past(host_wr));

  // R12
  rvalid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(host_rd && !host_wr, 2));

  // R6
  wr_index_chk: assert property (@(posedge clk) disable iff (rst)
    tf_wr |-> (tf_index != OFF_DATA_HI && tf_index != OFF_ERRFEAT &&
               tf_index != OFF_CTLSTAT));

  // R7
  rd_index_chk: assert property (@(posedge clk) disable iff (rst)
    tf_rd |-> (tf_index != OFF_DATA_HI && tf_index != OFF_ERRFEAT &&
               tf_index != OFF_CTLSTAT && tf_index != OFF_DEVADDR));

  // R10
  wake_pair_chk: assert property (@(posedge clk) disable iff (rst)
    pwrdn_clr |-> (crdy_set && tf_wr && $past(pwrdn_state)));

endmodule

// File: tb/test_ata_window_decoder.sv
module test_ata_window_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        mode;
  logic [ADDR_W-1:0] host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic              host_rd, host_wr;
  logic [DATA_W-1:0] host_rdata;
  logic              host_rvalid;
  logic              tf_rd, tf_wr;
  logic [3:0]        tf_index;
  logic [DATA_W-1:0] tf_wdata;
  logic [DATA_W-1:0] drive_rdata;
  logic              drive_present;
  logic [7:0]        drive_status;
  logic [3:0]        drive_sel;
  logic              pwrdn_state;
  logic              pwrdn_clr, crdy_set;
  logic [7:0]        devctl;
  logic              card_reset;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] m_devctl = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] drv_model(input logic [3:0] i);
    return {4'h9, i, 4'h3, i};
  endfunction

  assign drive_rdata = drv_model(tf_index);

  ata_window_decoder i_ata_window_decoder (
    .clk(clk), .rst(rst), .mode(mode), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_wr(host_wr),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_index(tf_index), .tf_wdata(tf_wdata),
    .drive_rdata(drive_rdata), .drive_present(drive_present),
    .drive_status(drive_status), .drive_sel(drive_sel),
    .pwrdn_state(pwrdn_state), .pwrdn_clr(pwrdn_clr), .crdy_set(crdy_set),
    .devctl(devctl), .card_reset(card_reset)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_off(input int md, input int a);
    case (md)
      0: return (a >= 'h400 && a <= 'h7FF) ? 4'h0 : 4'(a);
      1: return 4'(a);
      2: return (a >= 'h3F0 && a <= 'h3FF) ? 4'(a - 'h3E8) : 4'(a);
      default: return (a >= 'h370 && a <= 'h37F) ? 4'(a - 'h368) : 4'(a);
    endcase
  endfunction

  function automatic logic [3:0] ref_idx(input logic [3:0] o);
    if (o == 4'h0 || o == 4'h8) return 4'h0;
    if (o == 4'hD) return 4'h1;
    return o;
  endfunction

  task automatic do_write(input string req, input int md, input int a,
                          input logic [15:0] d, input bit pd);
    logic [3:0] o;
    bit loc, wk;
    o   = ref_off(md, a);
    loc = (o == 4'hE);
    wk  = pd && !(o == 4'h0 || o == 4'h8 || o == 4'hD || loc);
    @(negedge clk);
    mode = 2'(md); host_addr = ADDR_W'(a); host_wdata = d;
    pwrdn_state = pd; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; pwrdn_state = 1'b0;
    chk(tf_wr == !loc, req, "tf_wr", 32'(tf_wr), 32'(!loc));
    if (!loc) begin
      chk(tf_index == ref_idx(o), req, "wr index", 32'(tf_index), 32'(ref_idx(o)));
      chk(tf_wdata == d, req, "wr data", 32'(tf_wdata), 32'(d));
      chk(card_reset == 1'b0, req, "no reset", 32'(card_reset), 0);
    end else begin
      if (d[2]) m_devctl = 8'h00; else m_devctl = d[7:0];
      chk(card_reset == d[2], req, "card_reset", 32'(card_reset), 32'(d[2]));
    end
    chk(devctl == m_devctl, req, "devctl", 32'(devctl), 32'(m_devctl));
    chk(pwrdn_clr == wk && crdy_set == wk, req, "wake pulses",
        32'({pwrdn_clr, crdy_set}), 32'({wk, wk}));
  endtask

  task automatic do_read(input string req, input int md, input int a,
                         input bit pres, input logic [7:0] st,
                         input logic [3:0] sel);
    logic [3:0]  o;
    logic [15:0] e;
    bit loc;
    o   = ref_off(md, a);
    loc = (o == 4'hE || o == 4'hF);
    if (o == 4'hE)      e = pres ? {8'h00, st} : 16'h0000;
    else if (o == 4'hF) e = {8'h00, 8'hC2 | ((~{4'h0, sel} << 2) & 8'h3C)};
    else                e = drv_model(ref_idx(o));
    @(negedge clk);
    mode = 2'(md); host_addr = ADDR_W'(a); drive_present = pres;
    drive_status = st; drive_sel = sel; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk(tf_rd == !loc, req, "tf_rd", 32'(tf_rd), 32'(!loc));
    chk(tf_wr == 1'b0, req, "no tf_wr on read", 32'(tf_wr), 0);
    if (!loc)
      chk(tf_index == ref_idx(o), req, "rd index", 32'(tf_index), 32'(ref_idx(o)));
    chk(host_rvalid == 1'b0, req, "rvalid early", 32'(host_rvalid), 0);
    @(negedge clk);
    chk(host_rvalid == 1'b1, req, "rvalid", 32'(host_rvalid), 1);
    chk(host_rdata == e, req, "rdata", 32'(host_rdata), 32'(e));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    rst = 1'b1; mode = 2'd0; host_addr = '0; host_wdata = '0;
    host_rd = 1'b0; host_wr = 1'b0; drive_present = 1'b0;
    drive_status = 8'h00; drive_sel = 4'h0; pwrdn_state = 1'b0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(tf_rd == 0 && tf_wr == 0 && host_rvalid == 0, "R13", "strobes",
        32'({tf_rd, tf_wr, host_rvalid}), 0);
    chk(pwrdn_clr == 0 && crdy_set == 0 && card_reset == 0, "R13", "pulses",
        32'({pwrdn_clr, crdy_set, card_reset}), 0);
    chk(devctl == 0 && host_rdata == 0, "R13", "devctl/rdata",
        32'({devctl, host_rdata}), 0);
    rst = 1'b0;

    // R1 memory window edges and R5 outside it
    do_read ("R1", 0, 'h400, 1, 8'h50, 4'h0);
    do_read ("R1", 0, 'h7FF, 1, 8'h50, 4'h0);
    do_write("R1", 0, 'h5AB, 16'hBEEF, 1'b1);
    do_read ("R5", 0, 'h3F5, 1, 8'h50, 4'h0);
    do_write("R5", 0, 'h0F3, 16'h1234, 1'b0);
    // R2 contiguous I/O, R6 offset 0xD and 0x8
    do_read ("R2", 1, 'h12D, 1, 8'h50, 4'h0);
    do_write("R6", 1, 'h7D8, 16'hCAFE, 1'b1);
    do_write("R6", 1, 'h00D, 16'h0042, 1'b1);
    // R3 primary windows
    do_read ("R3", 2, 'h1F7, 1, 8'h58, 4'h0);
    do_read ("R3", 2, 'h3F0, 1, 8'h58, 4'h0);
    do_read ("R7", 2, 'h3F6, 1, 8'h58, 4'h0);
    do_read ("R7", 2, 'h3F6, 0, 8'h58, 4'h0);
    do_read ("R8", 2, 'h3F7, 1, 8'h00, 4'h0);
    do_read ("R8", 2, 'h3F7, 1, 8'h00, 4'hA);
    do_read ("R3", 2, 'h3FF, 1, 8'h00, 4'h0);
    // R4 secondary windows
    do_write("R4", 3, 'h177, 16'h00EC, 1'b1);
    do_read ("R4", 3, 'h376, 1, 8'hD0, 4'h0);
    do_read ("R4", 3, 'h37F, 1, 8'h00, 4'h0);
    do_read ("R5", 3, 'h3F6, 1, 8'hD0, 4'h0);
    // R9 device control
    do_write("R9", 3, 'h376, 16'h0002, 1'b1);
    do_write("R9", 1, 'h00E, 16'h00F6, 1'b0);
    // R10 offset 0xF write passes through and wakes
    do_write("R10", 2, 'h3F7, 16'h0011, 1'b1);
    do_write("R10", 2, 'h1F0, 16'h2222, 1'b1);

    // R11 pulses last a single cycle
    do_write("R11", 1, 'h003, 16'h0003, 1'b1);
    @(negedge clk);
    chk(tf_wr == 0 && pwrdn_clr == 0 && crdy_set == 0, "R11", "pulse width",
        32'({tf_wr, pwrdn_clr, crdy_set}), 0);

    // R12 read and write together
    @(negedge clk);
    mode = 2'd1; host_addr = 11'h005; host_wdata = 16'h5555;
    host_rd = 1'b1; host_wr = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    chk(tf_wr == 1 && tf_rd == 0, "R12", "write wins",
        32'({tf_wr, tf_rd}), 32'(2'b10));
    @(negedge clk);
    chk(host_rvalid == 0, "R12", "no read data", 32'(host_rvalid), 0);

    // Random accesses against the reference fold (R1..R10)
    for (int n = 0; n < 400; n++) begin
      int md, a, cat;
      md  = int'($urandom % 4);
      cat = int'($urandom % 6);
      case (cat)
        0: a = int'($urandom % 2048);
        1: a = 'h1F0 + int'($urandom % 16);
        2: a = 'h3F0 + int'($urandom % 16);
        3: a = 'h170 + int'($urandom % 16);
        4: a = 'h370 + int'($urandom % 16);
        default: a = 'h400 + int'($urandom % 1024);
      endcase
      if ($urandom % 2)
        do_write("R10", md, a, 16'($urandom), 1'($urandom));
      else
        do_read("R6", md, a, 1'($urandom), 8'($urandom), 4'($urandom));
    end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule